// File: doc/BRIEF.md
# Booth-Wallace FIR Filter

This block is a direct-form finite impulse response filter with a fixed number of taps. Each accepted signed sample is pushed into a delay line. Every tap multiplies one delayed sample by its own signed coefficient. The products are added at full precision, and one result comes out for each sample accepted.

Coefficients are written one tap at a time through a load port. A single shared radix-4 recoder turns the written coefficient into modified-Booth digits, each in {-2,-1,0,+1,+2}. The digits are stored with the tap, so the recoding logic exists once rather than once per multiplier. Each tap multiplier therefore holds only a partial-product selector and a carry-save (Wallace) reduction tree. That tree has no registers inside it. The summed taps are registered once, so a result appears one clock after its sample.

Top module: `bw_fir_filter`

## Requirements
- R1: After reset `outValid` is 0, `outData` is 0, and every coefficient is zero.
- R2: `outValid` is high in the cycle after each cycle in which `inValid` is high, and low otherwise. There is exactly one result per accepted sample.
- R3: For an accepted sample x[t], the result equals the sum over tap k (k = 0 to TAPS-1) of coef[k] * x[t-k]. Here x[t-k] is the k-th most recently accepted sample before x[t]. Cycles without `inValid` do not advance the delay line.
- R4: Delay-line entries that have not yet received a sample since reset count as zero.
- R5: When `coefLoad` is high, the signed value on `coefData` replaces the coefficient of the tap whose index is `coefAddr` (tap 0 multiplies the newest sample). The change applies from the next accepted sample. A sample accepted in the same cycle still uses the old coefficient.
- R6: A load whose `coefAddr` is TAPS or greater is ignored. Every coefficient is left unchanged.
- R7: `outData` is signed and N_BITS+M_BITS+ceil(log2 TAPS) bits wide. The result is exact even when every sample and coefficient is the most negative value.
- R8: `outData` holds its value in any cycle that follows a cycle without `inValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample accepted this cycle |
| inData | input | N_BITS (8) | Signed sample |
| coefLoad | input | 1 | Write a coefficient this cycle |
| coefAddr | input | AW (3) | Tap index for the write |
| coefData | input | M_BITS (8) | Signed coefficient value |
| outValid | output | 1 | Result valid |
| outData | output | W (19) | Signed full-precision filter result |

## Verification
The assertions take `inValid` and `coefLoad` to be known (never X) in every cycle after reset. They also take `coefAddr` to be meaningful only while a load is requested. The recoder and multiplier checks further assume that the widths keep the product within a 64-bit signed integer.

The stimulus drives every input at the falling edge with defined values and holds the strobes low between operations. It tries out-of-range addresses only as whole load operations, and it reaches the most negative sample and coefficient values without leaving the signed ranges of the ports.

// File: rtl/bw_fir_pkg.sv
package bw_fir_pkg;
  // One radix-4 Booth digit: magnitude select plus sign.
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } booth_digit_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic shift;
    logic load;
  } fir_strobe_t;
endpackage

// File: rtl/bw_booth_recoder.sv
module bw_booth_recoder
  import bw_fir_pkg::*;
#(
  parameter int M_BITS = 8,
  parameter int DIGITS = (M_BITS + 2) / 2
) (
  input  logic [M_BITS-1:0]        coef,
  output booth_digit_t [DIGITS-1:0] digits
);
  localparam int EXT = 2 * DIGITS + 1;

  logic [EXT-1:0] ext;
  assign ext = {{(EXT - 1 - M_BITS){coef[M_BITS-1]}}, coef, 1'b0};

  generate
    for (genvar j = 0; j < DIGITS; j++) begin : g_dig
      logic b2, b1, b0;
      assign b2 = ext[2*j+2];
      assign b1 = ext[2*j+1];
      assign b0 = ext[2*j];
      assign digits[j].one = b1 ^ b0;
      assign digits[j].two = (b2 & ~b1 & ~b0) | (~b2 & b1 & b0);
      assign digits[j].neg = b2 & ~(b1 & b0);
    end
  endgenerate

  // R3: the digit set must reproduce the coefficient exactly
  always_comb begin
    longint decoded;
    longint mag;
    decoded = 0;
    for (int j = 0; j < DIGITS; j++) begin
      mag = digits[j].two ? 2 : (digits[j].one ? 1 : 0);
      decoded += (digits[j].neg ? -mag : mag) * (longint'(1) <<< (2 * j));
    end
    assert_booth_exact_R3: assert (decoded == longint'($signed(coef)))
      else $error("Booth digits do not reproduce coefficient");
  end
endmodule

// File: rtl/bw_tap_mult.sv
module bw_tap_mult
  import bw_fir_pkg::*;
#(
  parameter int N_BITS = 8,
  parameter int M_BITS = 8,
  parameter int DIGITS = (M_BITS + 2) / 2
) (
  input  logic [N_BITS-1:0]         sample,
  input  booth_digit_t [DIGITS-1:0] digits,
  output logic [N_BITS+M_BITS-1:0]  product
);
  localparam int P    = N_BITS + M_BITS;
  localparam int ROWS = (DIGITS < 2) ? 2 : DIGITS;

  logic [P-1:0] xExt;
  logic [P-1:0] pp [ROWS];

  assign xExt = {{M_BITS{sample[N_BITS-1]}}, sample};

  // Partial-product generator driven by stored digits
  always_comb begin
    logic [P-1:0] mag;
    for (int r = 0; r < ROWS; r++) pp[r] = '0;
    for (int j = 0; j < DIGITS; j++) begin
      mag   = digits[j].two ? (xExt << 1) : (digits[j].one ? xExt : '0);
      pp[j] = (digits[j].neg ? (~mag + 1'b1) : mag) << (2 * j);
    end
  end

  // Wallace reduction: layers of 3:2 compressors, no registers
  always_comb begin
    logic [P-1:0] work [ROWS];
    logic [P-1:0] nxt  [ROWS];
    int cnt;
    int nc;
    for (int r = 0; r < ROWS; r++) work[r] = pp[r];
    cnt = ROWS;
    for (int lv = 0; lv < ROWS; lv++) begin
      for (int r = 0; r < ROWS; r++) nxt[r] = '0;
      nc = 0;
      for (int i = 0; i < ROWS; i += 3) begin
        if (i + 2 < cnt) begin
          nxt[nc]     = work[i] ^ work[i+1] ^ work[i+2];
          nxt[nc + 1] = ((work[i] & work[i+1]) | (work[i] & work[i+2]) |
                         (work[i+1] & work[i+2])) << 1;
          nc += 2;
        end else if (i < cnt) begin
          nxt[nc] = work[i];
          nc += 1;
          if (i + 1 < cnt) begin
            nxt[nc] = work[i+1];
            nc += 1;
          end
        end
      end
      if (cnt > 2) begin
        for (int r = 0; r < ROWS; r++) work[r] = nxt[r];
        cnt = nc;
      end
    end
    product = work[0] + work[1];
  end

  // R3: the tree output equals the true signed product
  always_comb begin
    longint dv;
    longint mag;
    dv = 0;
    for (int j = 0; j < DIGITS; j++) begin
      mag = digits[j].two ? 2 : (digits[j].one ? 1 : 0);
      dv += (digits[j].neg ? -mag : mag) * (longint'(1) <<< (2 * j));
    end
    assert_tree_product_R3: assert (longint'($signed(product)) == longint'($signed(sample)) * dv)
      else $error("Wallace tree product mismatch");
  end
endmodule

// File: rtl/bw_fir_control.sv
module bw_fir_control
  import bw_fir_pkg::*;
#(
  parameter int TAPS = 5,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          coefLoad,
  input  logic [AW-1:0] coefAddr,
  output fir_strobe_t   strb,
  output logic          outValid
);
  always_comb begin
    strb.shift = inValid;
    strb.load  = coefLoad && (int'(coefAddr) < TAPS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid) else $error("missing result valid");
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid) else $error("spurious result valid");
  assert_range_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coefLoad && int'(coefAddr) >= TAPS) |-> !strb.load) else $error("out-of-range load passed");
endmodule

// File: rtl/bw_fir_datapath.sv
module bw_fir_datapath
  import bw_fir_pkg::*;
#(
  parameter int N_BITS = 8,
  parameter int M_BITS = 8,
  parameter int TAPS   = 5,
  parameter int AW     = 3,
  parameter int W      = N_BITS + M_BITS + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fir_strobe_t       strb,
  input  logic [N_BITS-1:0] inData,
  input  logic [AW-1:0]     coefAddr,
  input  logic [M_BITS-1:0] coefData,
  output logic [W-1:0]      outData
);
  localparam int DIGITS = (M_BITS + 2) / 2;
  localparam int P      = N_BITS + M_BITS;

  booth_digit_t [DIGITS-1:0]            newDigits;
  booth_digit_t [TAPS-1:0][DIGITS-1:0]  coefDigits;
  logic [TAPS-1:0][N_BITS-1:0]          tapSample;
  logic [P-1:0]                         prod [TAPS];
  logic signed [W-1:0]                  tapSum;

  // Shared recoder: the only Booth encoding logic in the filter
  bw_booth_recoder #(.M_BITS(M_BITS), .DIGITS(DIGITS)) recoder_i (
    .coef   (coefData),
    .digits (newDigits)
  );

  // Per-tap digit storage and delay line
  assign tapSample[0] = inData;
  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                 coefDigits[k] <= '0;
        else if (strb.load && int'(coefAddr) == k) coefDigits[k] <= newDigits;
      end
      if (k > 0) begin : g_dly
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)           tapSample[k] <= '0;
          else if (strb.shift) tapSample[k] <= tapSample[k-1];
        end
      end
      bw_tap_mult #(.N_BITS(N_BITS), .M_BITS(M_BITS), .DIGITS(DIGITS)) mult_i (
        .sample  (tapSample[k]),
        .digits  (coefDigits[k]),
        .product (prod[k])
      );
    end
  endgenerate

  always_comb begin
    tapSum = '0;
    for (int k = 0; k < TAPS; k++) tapSum = tapSum + W'($signed(prod[k]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outData <= '0;
    else if (strb.shift) outData <= tapSum;
  end

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(outData)) else $error("result changed without sample");
  assert_coef_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(coefDigits)) else $error("coefficient changed without load");
  assert_coef_written_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> coefDigits[$past(coefAddr)] == $past(newDigits))
    else $error("coefficient write lost");
endmodule

// File: rtl/bw_fir_filter.sv
module bw_fir_filter
  import bw_fir_pkg::*;
#(
  parameter int N_BITS = 8,
  parameter int M_BITS = 8,
  parameter int TAPS   = 5,
  localparam int AW    = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int W     = N_BITS + M_BITS + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [N_BITS-1:0] inData,
  input  logic              coefLoad,
  input  logic [AW-1:0]     coefAddr,
  input  logic [M_BITS-1:0] coefData,
  output logic              outValid,
  output logic [W-1:0]      outData
);
  fir_strobe_t strb;

  bw_fir_control #(.TAPS(TAPS), .AW(AW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .coefLoad (coefLoad),
    .coefAddr (coefAddr),
    .strb     (strb),
    .outValid (outValid)
  );

  bw_fir_datapath #(.N_BITS(N_BITS), .M_BITS(M_BITS), .TAPS(TAPS), .AW(AW), .W(W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inData   (inData),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .outData  (outData)
  );
endmodule

// File: tb/bw_fir_filter_tb_top.sv
module bw_fir_filter_tb_top;
  localparam int N  = 8;
  localparam int M  = 8;
  localparam int K  = 5;
  localparam int AW = 3;
  localparam int W  = N + M + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [N-1:0] inData = '0;
  logic coefLoad = 1'b0;
  logic [AW-1:0] coefAddr = '0;
  logic [M-1:0] coefData = '0;
  logic outValid;
  logic [W-1:0] outData;

  int checks = 0;
  int errors = 0;

  typedef struct {
    longint val;
    string  tag;
  } exp_t;
  exp_t expQ[$];

  longint coefModel[K];
  longint histModel[K];
  longint lastOut = 0;

  always #2 clk = ~clk;

  bw_fir_filter #(.N_BITS(N), .M_BITS(M), .TAPS(K)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .coefLoad(coefLoad), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint modelPush(input longint x);
    longint s = 0;
    for (int k = K - 1; k > 0; k--) histModel[k] = histModel[k-1];
    histModel[0] = x;
    for (int k = 0; k < K; k++) s += coefModel[k] * histModel[k];
    return s;
  endfunction

  // Driver: one sample, optionally with a coefficient load in the same cycle (R5)
  task automatic sendSample(input longint x, input string tag,
                            input bit withLoad = 0, input int addr = 0, input longint c = 0);
    exp_t e;
    inValid = 1'b1;
    inData  = N'(x);
    coefLoad = withLoad;
    coefAddr = AW'(addr);
    coefData = M'(c);
    e.val = modelPush(x);
    e.tag = tag;
    expQ.push_back(e);
    if (withLoad && addr < K) coefModel[addr] = c;
    @(negedge clk);
    inValid = 1'b0;
    coefLoad = 1'b0;
  endtask

  task automatic loadCoef(input int addr, input longint c);
    coefLoad = 1'b1;
    coefAddr = AW'(addr);
    coefData = M'(c);
    if (addr < K) coefModel[addr] = c;
    @(negedge clk);
    coefLoad = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", longint'($signed(outData)), 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(longint'($signed(outData)) == e.val, e.tag, longint'($signed(outData)), e.val);
        end
        lastOut = longint'($signed(outData));
      end else begin
        check(longint'($signed(outData)) == lastOut, "R8 hold", longint'($signed(outData)), lastOut);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < K; k++) begin coefModel[k] = 0; histModel[k] = 0; end
    idle(3);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid", longint'(outValid), 0);
    check(outData == '0, "R1 outData", longint'($signed(outData)), 0);
    rstN = 1'b1;
    idle(2);
    // R1: zero coefficients give zero result
    sendSample(100, "R1 zero coefs");
    idle(1);

    // R4 / R5: impulse response after loading 1..5
    for (int k = 0; k < K; k++) loadCoef(k, k + 1);
    rstN = 1'b0; idle(1); rstN = 1'b1; idle(1);
    lastOut = 0;
    for (int k = 0; k < K; k++) histModel[k] = 0;
    for (int k = 0; k < K; k++) coefModel[k] = 0;
    for (int k = 0; k < K; k++) loadCoef(k, k + 1);
    sendSample(1, "R4 empty history");
    for (int k = 1; k < K; k++) sendSample(0, "R5 impulse tap");
    idle(2);

    // R3: random signed data with gaps
    for (int k = 0; k < K; k++) loadCoef(k, $signed(M'($urandom)));
    for (int i = 0; i < 60; i++) begin
      sendSample($signed(N'($urandom)), "R3 random");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(2);

    // R6: out-of-range addresses ignored
    for (int a = K; a < (1 << AW); a++) loadCoef(a, 77);
    for (int i = 0; i < K; i++) sendSample($signed(N'($urandom)), "R6 ignored load");
    idle(1);

    // R5: load in the same cycle as a sample
    sendSample(50, "R5 same-cycle old coef", 1'b1, 0, -3);
    sendSample(-20, "R5 new coef applied");
    sendSample(7, "R5 new coef applied");
    idle(2);

    // R7: extreme values
    for (int k = 0; k < K; k++) loadCoef(k, -128);
    for (int i = 0; i < K; i++) sendSample(-128, "R7 most negative");
    for (int i = 0; i < K; i++) sendSample(127, "R7 max times min");
    idle(3);

    // R2: every accepted sample produced one result
    check(expQ.size() == 0, "R2 outstanding results", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule